// File: doc/BRIEF.md
# Window and Orientation Command Generator

This block sits between a pixel producer and the serial transmitter of a small colour panel whose native raster is 176 columns by 220 rows. For each window request it receives a rotation code, a red/blue swap flag and the four corners of a pixel rectangle. It then emits a burst of controller bytes, each tagged with a data/command flag. The burst sets the memory access orientation, programs the column range and the row range, and opens a memory write. After the burst it passes a stream of 16-bit pixels to the transmitter as parameter bytes.

The orientation command is sent only when needed: on the first window after reset, and whenever the rotation or the swap flag differs from the last window that was accepted. A window that does not fit the rotated panel, or whose start lies beyond its end, is refused with a one-cycle error pulse, and no byte leaves the block. A new window request can also be accepted while pixels are streaming. It waits until the pixel in flight has left completely.

All transfers use valid/ready handshakes. The output byte and its flag hold steady while the transmitter stalls.

Top module: `win_orient_gen`

## Requirements
- R1: After reset, out_vld and req_err are 0, req_rdy is 1 and pix_rdy is 0.
- R2: The orientation parameter byte puts vertical mirror in bit 7, horizontal mirror in bit 6, axis exchange in bit 5 and red/blue swap in bit 3, with all other bits 0. The rotation codes 0, 1, 2 and 3 stand for 0, 90, 180 and 270 degrees. With the swap flag clear they give 0x00, 0xA0, 0xC0 and 0x60.
- R3: Command 0x36 (out_dc=0), followed by the orientation byte (out_dc=1), opens the burst on the first accepted window after reset. It also opens the burst whenever the rotation or the swap flag differs from the last accepted window. Otherwise the burst starts at the column command.
- R4: The column range is sent as command 0x2A and then four parameter bytes: 0x00, x start, 0x00, x end.
- R5: The row range follows directly as command 0x2B and parameter bytes 0x00, y start, 0x00, y end. Command 0x2C comes right after it, with no parameters.
- R6: After 0x2C, every accepted pixel produces two parameter bytes (out_dc=1), the high byte first and then the low byte.
- R7: A window is refused in any of these cases: x start > x end, y start > y end, x end is not below the rotated width, or y end is not below the rotated height. The rotated size is 176x220 for codes 0 and 2, and 220x176 for codes 1 and 3. A refused window raises req_err for the one cycle after acceptance. It emits no byte and leaves the remembered orientation unchanged.
- R8: While out_vld is high and out_rdy is low, out_vld, out_byte and out_dc keep their values into the next cycle.
- R9: A window request is accepted only when idle, or in the pixel phase with no pixel byte pending. During the pixel phase, pix_rdy is 0 while req_vld is high. A request and a pixel are never taken in the same cycle.
- R10: Windows that reach the last column and row of the rotated panel are accepted: 175/219 for code 0, and 219/175 for code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Window request valid |
| req_rdy | output | 1 | Window request can be taken |
| req_rot | input | 2 | Rotation code 0..3 (0/90/180/270 degrees) |
| req_bgr | input | 1 | Red/blue swap flag |
| req_xs | input | COORD_W | First column of the window |
| req_xe | input | COORD_W | Last column of the window |
| req_ys | input | COORD_W | First row of the window |
| req_ye | input | COORD_W | Last row of the window |
| req_err | output | 1 | One-cycle pulse: last taken window was refused |
| pix_vld | input | 1 | Pixel valid |
| pix_rdy | output | 1 | Pixel can be taken |
| pix_data | input | 16 | Pixel value |
| out_vld | output | 1 | Output byte valid |
| out_rdy | input | 1 | Transmitter takes the byte |
| out_dc | output | 1 | 0 = command byte, 1 = parameter or pixel byte |
| out_byte | output | 8 | Byte to the transmitter |

## Verification
The header step counter and the remembered orientation can only be seen through the byte stream. A wrong step shows up as a misplaced opcode or coordinate byte on the very next transfer after acceptance. A wrong orientation memory shows up one window later, as a missing or extra 0x36 at the head of the burst. A pixel half-select fault swaps the byte order on the first pixel. A stalled-output fault changes out_byte in the cycle right after a refused handshake. The scoreboard compares every transferred byte in order while the transmitter is stalled at random, so each of these faults is reported at the first byte it touches.

// File: rtl/wocg_pkg.sv
`timescale 1ns/1ps
package wocg_pkg;
   localparam logic [7:0] OP_ORIENT = 8'h36;
   localparam logic [7:0] OP_COLS   = 8'h2A;
   localparam logic [7:0] OP_ROWS   = 8'h2B;
   localparam logic [7:0] OP_MEMWR  = 8'h2C;
   // header steps: 0..1 orientation, 2..6 columns, 7..11 rows, 12 memory write
   localparam int ORI_STEPS = 2;
   localparam int HDR_LAST  = 12;

   typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PIX} seq_st_t;

   function automatic logic [7:0] orient_byte(input logic [1:0] rot, input logic bgr);
      logic flip_v, flip_h, swap_xy;
      flip_v  = (rot == 2'd1) || (rot == 2'd2);
      flip_h  = (rot == 2'd2) || (rot == 2'd3);
      swap_xy = rot[0];
      return {flip_v, flip_h, swap_xy, 1'b0, bgr, 3'b000};
   endfunction
endpackage

// File: rtl/wocg_check.sv
`timescale 1ns/1ps
module wocg_check #(
   parameter int COORD_W = 8,
   parameter int NAT_W   = 176,
   parameter int NAT_H   = 220
) (
   input  logic               swap_i,
   input  logic [COORD_W-1:0] xs_i,
   input  logic [COORD_W-1:0] xe_i,
   input  logic [COORD_W-1:0] ys_i,
   input  logic [COORD_W-1:0] ye_i,
   output logic               bad_o
);
   localparam logic [16:0] LIM_A = 17'(NAT_W);
   localparam logic [16:0] LIM_B = 17'(NAT_H);

   logic [16:0] lim_x, lim_y;

   always_comb begin
      lim_x = swap_i ? LIM_B : LIM_A;
      lim_y = swap_i ? LIM_A : LIM_B;
      bad_o = (xs_i > xe_i) || (ys_i > ye_i) ||
              (17'(xe_i) >= lim_x) || (17'(ye_i) >= lim_y);
   end
endmodule

// File: rtl/wocg_hdr.sv
`timescale 1ns/1ps
module wocg_hdr
   import wocg_pkg::*;
#(
   parameter int COORD_W = 8
) (
   input  logic [3:0]         step_i,
   input  logic [7:0]         orient_i,
   input  logic [COORD_W-1:0] xs_i,
   input  logic [COORD_W-1:0] xe_i,
   input  logic [COORD_W-1:0] ys_i,
   input  logic [COORD_W-1:0] ye_i,
   output logic               dc_o,
   output logic [7:0]         byte_o
);
   logic [15:0] xs_w, xe_w, ys_w, ye_w;

   always_comb begin
      xs_w = 16'(xs_i);
      xe_w = 16'(xe_i);
      ys_w = 16'(ys_i);
      ye_w = 16'(ye_i);
      dc_o = 1'b1;
      unique case (step_i)
         4'd0:    begin dc_o = 1'b0; byte_o = OP_ORIENT; end
         4'd1:    byte_o = orient_i;
         4'd2:    begin dc_o = 1'b0; byte_o = OP_COLS; end
         4'd3:    byte_o = xs_w[15:8];
         4'd4:    byte_o = xs_w[7:0];
         4'd5:    byte_o = xe_w[15:8];
         4'd6:    byte_o = xe_w[7:0];
         4'd7:    begin dc_o = 1'b0; byte_o = OP_ROWS; end
         4'd8:    byte_o = ys_w[15:8];
         4'd9:    byte_o = ys_w[7:0];
         4'd10:   byte_o = ye_w[15:8];
         4'd11:   byte_o = ye_w[7:0];
         default: begin dc_o = 1'b0; byte_o = OP_MEMWR; end
      endcase
   end
endmodule

// File: rtl/wocg_pix.sv
`timescale 1ns/1ps
module wocg_pix #(
   parameter bit HI_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_i,
   input  logic [15:0] word_i,
   input  logic        adv_i,
   output logic        pend_o,
   output logic        half_o,
   output logic [7:0]  byte_o
);
   logic [15:0] word_q;
   logic        pend_q, half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         pend_q <= 1'b0;
         half_q <= 1'b0;
      end else if (load_i) begin
         word_q <= word_i;
         pend_q <= 1'b1;
         half_q <= 1'b0;
      end else if (adv_i) begin
         if (half_q) pend_q <= 1'b0;
         half_q <= ~half_q;
      end
   end

   generate
      if (HI_FIRST) begin : g_hi_first
         assign byte_o = half_q ? word_q[7:0] : word_q[15:8];
      end else begin : g_lo_first
         assign byte_o = half_q ? word_q[15:8] : word_q[7:0];
      end
   endgenerate

   assign pend_o = pend_q;
   assign half_o = half_q;
endmodule

// File: rtl/win_orient_gen.sv
`timescale 1ns/1ps
module win_orient_gen
   import wocg_pkg::*;
#(
   parameter int COORD_W  = 8,
   parameter int NAT_W    = 176,
   parameter int NAT_H    = 220,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_vld,
   output logic               req_rdy,
   input  logic [1:0]         req_rot,
   input  logic               req_bgr,
   input  logic [COORD_W-1:0] req_xs,
   input  logic [COORD_W-1:0] req_xe,
   input  logic [COORD_W-1:0] req_ys,
   input  logic [COORD_W-1:0] req_ye,
   output logic               req_err,
   input  logic               pix_vld,
   output logic               pix_rdy,
   input  logic [15:0]        pix_data,
   output logic               out_vld,
   input  logic               out_rdy,
   output logic               out_dc,
   output logic [7:0]         out_byte
);
   localparam logic [3:0] STEP_ORI  = 4'd0;
   localparam logic [3:0] STEP_COLS = 4'(ORI_STEPS);
   localparam logic [3:0] STEP_LAST = 4'(HDR_LAST);

   generate
      if (COORD_W < 8 || COORD_W > 16) begin : g_bad_width
         $error("COORD_W must lie in 8..16");
      end
      if (NAT_W > (1 << COORD_W) || NAT_H > (1 << COORD_W)) begin : g_bad_size
         $error("panel size does not fit COORD_W");
      end
   endgenerate

   seq_st_t            st_q;
   logic [3:0]         step_q;
   logic [7:0]         ori_q;
   logic [COORD_W-1:0] xs_q, xe_q, ys_q, ye_q;
   logic [1:0]         last_rot_q;
   logic               last_bgr_q, known_q, err_q;

   logic win_bad, need_ori, req_go, pix_go, pix_adv;
   logic pend, half, hdr_dc;
   logic [7:0] hdr_byte, pix_byte;

   wocg_check #(.COORD_W(COORD_W), .NAT_W(NAT_W), .NAT_H(NAT_H)) u_check (
      .swap_i(req_rot[0]), .xs_i(req_xs), .xe_i(req_xe),
      .ys_i(req_ys), .ye_i(req_ye), .bad_o(win_bad)
   );

   wocg_hdr #(.COORD_W(COORD_W)) u_hdr (
      .step_i(step_q), .orient_i(ori_q), .xs_i(xs_q), .xe_i(xe_q),
      .ys_i(ys_q), .ye_i(ye_q), .dc_o(hdr_dc), .byte_o(hdr_byte)
   );

   wocg_pix #(.HI_FIRST(HI_FIRST)) u_pix (
      .clk(clk), .rst_n(rst_n), .load_i(pix_go), .word_i(pix_data),
      .adv_i(pix_adv), .pend_o(pend), .half_o(half), .byte_o(pix_byte)
   );

   always_comb begin
      need_ori = !known_q || (req_rot != last_rot_q) || (req_bgr != last_bgr_q);
      req_rdy  = (st_q == ST_IDLE) || ((st_q == ST_PIX) && !pend);
      req_go   = req_vld && req_rdy;
      pix_rdy  = (st_q == ST_PIX) && !req_vld && (!pend || (half && out_rdy));
      pix_go   = pix_vld && pix_rdy;
      pix_adv  = (st_q == ST_PIX) && pend && out_rdy;
      out_vld  = (st_q == ST_HDR) || ((st_q == ST_PIX) && pend);
      out_dc   = (st_q == ST_HDR) ? hdr_dc : 1'b1;
      out_byte = (st_q == ST_HDR) ? hdr_byte : pix_byte;
      req_err  = err_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         step_q     <= '0;
         ori_q      <= '0;
         xs_q       <= '0;
         xe_q       <= '0;
         ys_q       <= '0;
         ye_q       <= '0;
         last_rot_q <= '0;
         last_bgr_q <= 1'b0;
         known_q    <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         err_q <= req_go && win_bad;
         if (req_go && !win_bad) begin
            st_q       <= ST_HDR;
            step_q     <= need_ori ? STEP_ORI : STEP_COLS;
            ori_q      <= orient_byte(req_rot, req_bgr);
            xs_q       <= req_xs;
            xe_q       <= req_xe;
            ys_q       <= req_ys;
            ye_q       <= req_ye;
            last_rot_q <= req_rot;
            last_bgr_q <= req_bgr;
            known_q    <= 1'b1;
         end else if (st_q == ST_HDR && out_rdy) begin
            if (step_q == STEP_LAST) st_q <= ST_PIX;
            else                     step_q <= step_q + 4'd1;
         end
      end
   end
endmodule

// File: rtl/win_orient_gen_chk.sv
`timescale 1ns/1ps
module win_orient_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_vld,
   input logic       req_rdy,
   input logic       req_err,
   input logic       pix_vld,
   input logic       pix_rdy,
   input logic       out_vld,
   input logic       out_rdy,
   input logic       out_dc,
   input logic [7:0] out_byte
);
   AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && !out_rdy |=> out_vld && $stable(out_byte) && $stable(out_dc)); // R8

   AST_BURST_OPENS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && req_rdy |=> req_err || (out_vld && !out_dc)); // R3

   AST_BURST_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && req_rdy |=> req_err || out_byte == 8'h36 || out_byte == 8'h2A); // R4

   AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> !out_vld); // R7

   AST_PIXEL_AS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld && pix_rdy |=> out_vld && out_dc); // R6

   AST_NO_DUAL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_vld && req_rdy && pix_vld && pix_rdy)); // R9
endmodule

bind win_orient_gen win_orient_gen_chk u_chk_bound (
   .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rdy(req_rdy),
   .req_err(req_err), .pix_vld(pix_vld), .pix_rdy(pix_rdy),
   .out_vld(out_vld), .out_rdy(out_rdy), .out_dc(out_dc), .out_byte(out_byte)
);

// File: tb/win_orient_gen_test.sv
`timescale 1ns/1ps
module win_orient_gen_test;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_vld = 1'b0;
   logic req_rdy;
   logic [1:0] req_rot = '0;
   logic req_bgr = 1'b0;
   logic [CW-1:0] req_xs = '0, req_xe = '0, req_ys = '0, req_ye = '0;
   logic req_err;
   logic pix_vld = 1'b0;
   logic pix_rdy;
   logic [15:0] pix_data = '0;
   logic out_vld;
   logic out_rdy = 1'b0;
   logic out_dc;
   logic [7:0] out_byte;

   int n_chk = 0;
   int n_bad = 0;
   bit stall_all = 1'b0;
   bit run_rdy = 1'b0;

   logic [8:0] exp_q[$];
   string      tag_q[$];

   logic [1:0] m_rot = '0;
   logic       m_bgr = 1'b0;
   bit         m_known = 1'b0;

   always #2.5 clk = ~clk;

   win_orient_gen #(.COORD_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rdy(req_rdy),
      .req_rot(req_rot), .req_bgr(req_bgr), .req_xs(req_xs), .req_xe(req_xe),
      .req_ys(req_ys), .req_ye(req_ye), .req_err(req_err),
      .pix_vld(pix_vld), .pix_rdy(pix_rdy), .pix_data(pix_data),
      .out_vld(out_vld), .out_rdy(out_rdy), .out_dc(out_dc), .out_byte(out_byte)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic dc, input logic [7:0] b, input string t);
      exp_q.push_back({dc, b});
      tag_q.push_back(t);
   endtask

   function automatic logic [7:0] model_ori(input logic [1:0] r, input logic g);
      logic [7:0] v;
      case (r)
         2'd0: v = 8'h00;
         2'd1: v = 8'hA0;
         2'd2: v = 8'hC0;
         default: v = 8'h60;
      endcase
      return v | (g ? 8'h08 : 8'h00);
   endfunction

   task automatic push_hdr(input logic [1:0] r, input logic g,
                           input logic [7:0] xs, input logic [7:0] xe,
                           input logic [7:0] ys, input logic [7:0] ye);
      if (!m_known || r != m_rot || g != m_bgr) begin
         push(1'b0, 8'h36, "R3");
         push(1'b1, model_ori(r, g), "R2");
      end
      push(1'b0, 8'h2A, "R4"); push(1'b1, 8'h00, "R4"); push(1'b1, xs, "R4");
      push(1'b1, 8'h00, "R4"); push(1'b1, xe, "R4");
      push(1'b0, 8'h2B, "R5"); push(1'b1, 8'h00, "R5"); push(1'b1, ys, "R5");
      push(1'b1, 8'h00, "R5"); push(1'b1, ye, "R5");
      push(1'b0, 8'h2C, "R5");
      m_known = 1'b1; m_rot = r; m_bgr = g;
   endtask

   function automatic bit model_bad(input logic [1:0] r, input int xs, input int xe,
                                    input int ys, input int ye);
      int lx, ly;
      lx = r[0] ? 220 : 176;
      ly = r[0] ? 176 : 220;
      return (xs > xe) || (ys > ye) || (xe >= lx) || (ye >= ly);
   endfunction

   task automatic finish_req(input logic [1:0] r, input logic g,
                             input logic [7:0] xs, input logic [7:0] xe,
                             input logic [7:0] ys, input logic [7:0] ye,
                             input string tag);
      bit bad;
      bad = model_bad(r, xs, xe, ys, ye);
      do @(negedge clk); while (!req_rdy);
      if (!bad) push_hdr(r, g, xs, xe, ys, ye);
      @(posedge clk); #1;
      req_vld = 1'b0;
      pix_vld = 1'b0;
      @(negedge clk);
      chk(req_err == bad, "R7", {tag, " error flag"}, int'(req_err), int'(bad));
      if (bad) chk(!out_vld, "R7", {tag, " no bytes after refusal"}, int'(out_vld), 0);
   endtask

   task automatic do_req(input logic [1:0] r, input logic g,
                         input logic [7:0] xs, input logic [7:0] xe,
                         input logic [7:0] ys, input logic [7:0] ye,
                         input string tag);
      @(posedge clk); #1;
      req_vld = 1'b1; req_rot = r; req_bgr = g;
      req_xs = xs; req_xe = xe; req_ys = ys; req_ye = ye;
      finish_req(r, g, xs, xe, ys, ye, tag);
   endtask

   task automatic send_pix(input logic [15:0] d);
      @(posedge clk); #1;
      pix_vld = 1'b1; pix_data = d;
      do @(negedge clk); while (!pix_rdy);
      push(1'b1, d[15:8], "R6");
      push(1'b1, d[7:0], "R6");
      @(posedge clk); #1;
      pix_vld = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // transmitter ready pattern
   initial begin
      forever begin
         @(posedge clk); #1;
         out_rdy = run_rdy && !stall_all && (($urandom % 4) != 0);
      end
   end

   // monitor: compares every transferred byte and the stall hold rule
   initial begin
      logic       prev_stall;
      logic [8:0] prev_out;
      logic [8:0] e;
      string      t;
      prev_stall = 1'b0;
      prev_out = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (prev_stall)
               chk(out_vld && {out_dc, out_byte} == prev_out, "R8", "stalled output held",
                   int'({out_vld, out_dc, out_byte}), int'({1'b1, prev_out}));
            if (out_vld && out_rdy) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R6", "unexpected byte", int'({out_dc, out_byte}), 0);
               end else begin
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  chk({out_dc, out_byte} == e, t, "stream byte {dc,byte}",
                      int'({out_dc, out_byte}), int'(e));
               end
            end
            prev_stall = out_vld && !out_rdy;
            prev_out = {out_dc, out_byte};
         end
      end
   end

   // watchdog
   initial begin
      #(5ns * 100000);
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_vld, "R1", "out_vld after reset", int'(out_vld), 0);
      chk(!req_err, "R1", "req_err after reset", int'(req_err), 0);
      chk(req_rdy, "R1", "req_rdy after reset", int'(req_rdy), 1);
      chk(!pix_rdy, "R1", "pix_rdy after reset", int'(pix_rdy), 0);
      run_rdy = 1'b1;

      // first window: orientation always sent (R3), code 0 (R2)
      do_req(2'd0, 1'b0, 8'd10, 8'd30, 8'd20, 8'd40, "R4 first window");
      send_pix(16'hA55A);
      send_pix(16'h0102);
      send_pix(16'hFF00);
      drain();

      // same orientation: no 0x36 (R3); full native extent (R10)
      do_req(2'd0, 1'b0, 8'd0, 8'd175, 8'd0, 8'd219, "R10 full code 0");
      send_pix(16'h1357);
      send_pix(16'h2468);
      drain();

      // rotated full extent with swap flag (R2, R10)
      do_req(2'd1, 1'b1, 8'd0, 8'd219, 8'd0, 8'd175, "R10 full code 1");
      send_pix(16'hBEEF);
      drain();

      // refusals: out of range, start beyond end, rotated limits (R7)
      do_req(2'd0, 1'b0, 8'd0, 8'd176, 8'd0, 8'd10, "R7 column past edge");
      do_req(2'd2, 1'b0, 8'd50, 8'd40, 8'd0, 8'd10, "R7 start beyond end");
      do_req(2'd1, 1'b1, 8'd0, 8'd10, 8'd0, 8'd176, "R7 rotated row limit");
      // orientation memory untouched by refusals: no 0x36 expected (R7, R3)
      do_req(2'd1, 1'b1, 8'd5, 8'd6, 8'd7, 8'd8, "R3 after refusals");
      send_pix(16'h00FF);
      drain();

      // remaining rotation codes (R2)
      do_req(2'd2, 1'b0, 8'd1, 8'd2, 8'd3, 8'd4, "R2 code 2");
      drain();
      do_req(2'd3, 1'b0, 8'd9, 8'd9, 8'd9, 8'd9, "R2 code 3");
      send_pix(16'h8001);
      drain();
      do_req(2'd3, 1'b1, 8'd0, 8'd1, 8'd0, 8'd1, "R3 swap flag change");
      drain();

      // request waits while a pixel is pending (R9)
      stall_all = 1'b1;
      send_pix(16'h1234);
      @(negedge clk);
      chk(!req_rdy, "R9", "req_rdy with pixel pending", int'(req_rdy), 0);
      @(posedge clk); #1;
      req_vld = 1'b1; req_rot = 2'd3; req_bgr = 1'b1;
      req_xs = 8'd2; req_xe = 8'd3; req_ys = 8'd4; req_ye = 8'd5;
      pix_vld = 1'b1; pix_data = 16'hDEAD;
      @(negedge clk);
      chk(!pix_rdy, "R9", "pix_rdy while request waits", int'(pix_rdy), 0);
      chk(!req_rdy, "R9", "req_rdy while stalled", int'(req_rdy), 0);
      stall_all = 1'b0;
      finish_req(2'd3, 1'b1, 8'd2, 8'd3, 8'd4, 8'd5, "R9 delayed request");
      send_pix(16'h4321);
      drain();

      chk(exp_q.size() == 0, "R6", "scoreboard empty at end", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule